// File: doc/BRIEF.md
# Cartridge Bus State Sequencer

This block sits between a console's address/data bus and a cartridge's memory mapper and decides, for every console bus cycle, what the cartridge does with the data bus. It can drive a byte, leave the bus floating, or emit a byte from an opcode injection queue. It keeps a small state machine with six states: plain access, one-shot fetch after a bank switch, deferred RAM write, waiting to start a long operation, busy, and injection. Each cycle strobe is judged against the address seen on the previous strobe and against the address latched when a deferred action began.

Writes that have side effects cannot be taken back, so they are not acted on at once. The block holds the write until the address moves in a bit other than 8 or 9, then commits it with a single strobe. A multi-cycle copy is launched the same way. The console is then kept busy with no-operation opcodes (0xEA) for a programmable number of cycles. After that a jump opcode (0x4C) and the fetched address are fed back to the console, so that execution resumes where it left off. The mapper supplies the read data, a bank-switch pulse and the per-access mode selects. The block only sequences.

Top module: `cart_bus_seq`

## Requirements
- R1: Outside the busy state, a strobe whose address equals the address of the previous strobe has no effect: the outputs and the state hold. The first strobe after reset is never treated as a repeat.
- R2: After a strobe with `bank_sw` high, strobes outside cartridge space (address bit 12 clear) float the bus and are otherwise ignored. The next cartridge-space read drives `rom_data` with `prev_offset` high, and the block then returns to plain access.
- R3: A cartridge-space strobe with `ram_wr_sel` high latches address and data. Each later strobe that differs from the latched address only in bits 8 and 9 re-latches both. The first strobe that differs elsewhere is served as a read with `prev_offset` high, and `wr_go` pulses for one cycle with the last latched `wr_addr`/`wr_data`. `wr_go` and `copy_go` never pulse together.
- R4: A cartridge-space write with `copy_sel` high arms a copy. The first later strobe that differs from it outside bits 8 and 9 and has bit 12 set drives 0xEA and pulses `copy_go`. It also loads the busy count from `copy_len_cycles` and queues the bytes 0x4C, address low byte, address high byte.
- R5: If that first differing strobe has bit 12 clear, the block floats the bus, launches no copy and returns to plain access.
- R6: In the busy state every strobe drives 0xEA and decrements a nonzero count. The strobe that finds the count at zero also drives 0xEA and moves to injection, or to plain access if the queue is empty. Busy therefore lasts `copy_len_cycles`+1 strobes after the launch.
- R7: In injection, each new cartridge-space address drives the low queue byte and shifts the queue down one byte. A non-cartridge address floats without shifting. The strobe that emits the last nonzero byte returns the block to plain access. Zero bytes in the middle of the queue are emitted.
- R8: A write strobe while the block drives (busy state, or the copy launch strobe) sets `contention_err`, which stays set until reset. A write in injection drives the queue byte and raises no error.
- R9: After reset the block is in plain access with the bus floating, no pulses, `contention_err` low, an empty queue and a zero busy count.
- R10: In plain access a cartridge-space read drives `rom_data`, and a write or a non-cartridge access floats the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | One console bus cycle is presented |
| addr | input | AW (13) | Console address; bit 12 selects cartridge space |
| data_in | input | DW (8) | Console write data |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| bank_sw | input | 1 | Mapper flags this access as a bank-switch address |
| ram_wr_sel | input | 1 | Mapper flags this access as a bank in RAM-write mode |
| copy_sel | input | 1 | Mapper flags this access as a bank in copy mode |
| rom_data | input | DW (8) | Read data from the mapper for this access |
| copy_len_cycles | input | CW (8) | Busy count loaded when a copy launches |
| drive_en | output | 1 | Cartridge drives the data bus |
| data_out | output | DW (8) | Byte on the data bus when driving |
| contention_err | output | 1 | Sticky bus contention flag |
| prev_offset | output | 1 | This read uses the bank offset of the previous read |
| wr_go | output | 1 | One-cycle strobe: commit the deferred write |
| wr_addr | output | AW (13) | Address of the deferred write |
| wr_data | output | DW (8) | Data of the deferred write |
| copy_go | output | 1 | One-cycle strobe: start the copy operation |

## Verification
The hardest case to reach from the ports is a console write that lands in injection while the queue still holds a zero middle byte. It needs a copy armed, a launch address with bit 12 set, and the busy count run down exactly to zero. The stimulus uses a zero copy length, so the third strobe after arming is the first injected one, and makes it a write. A second sequence uses a launch address whose low byte is zero and places a non-cartridge access inside the injection. This shows that the queue holds across the gap and still emits the zero byte before the high byte.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
   typedef enum logic [2:0] {
      ST_NORM   = 3'd0,
      ST_SFETCH = 3'd1,
      ST_FHW    = 3'd2,
      ST_EBUSY  = 3'd3,
      ST_BUSY   = 3'd4,
      ST_INJ    = 3'd5
   } cbs_state_e;

   localparam logic [7:0] NOP_OP = 8'hEA;
   localparam logic [7:0] JMP_OP = 8'h4C;
endpackage

// File: rtl/cbs_addr_track.sv
module cbs_addr_track #(
   parameter int AW       = 13,
   parameter int GUARD_LO = 8,
   parameter int GUARD_HI = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb,
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] ref_addr,
   output logic          repeat_o,
   output logic          far_move
);
   localparam logic [AW-1:0] GUARD_M =
      AW'((1 << (GUARD_HI + 1)) - (1 << GUARD_LO));

   generate
      if (GUARD_HI < GUARD_LO || GUARD_HI >= AW) begin : g_bad_guard
         $error("cbs_addr_track: guard bit range out of address width");
      end
   endgenerate

   logic [AW-1:0] prev_q;
   logic          prev_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= '0;
         prev_vld_q <= 1'b0;
      end else if (stb) begin
         prev_q     <= addr;
         prev_vld_q <= 1'b1;
      end
   end

   assign repeat_o = prev_vld_q && (addr == prev_q);
   assign far_move = |((addr ^ ref_addr) & ~GUARD_M);
endmodule

// File: rtl/cbs_busy_ctr.sv
module cbs_busy_ctr #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic          zero
);
   generate
      if (CW < 1) begin : g_bad_cw
         $error("cbs_busy_ctr: counter width must be positive");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R6
   busy_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cbs_inj_queue.sv
module cbs_inj_queue #(
   parameter int NB = 4,
   parameter int DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NB*DW-1:0] load_val,
   input  logic             shift,
   output logic [DW-1:0]    head,
   output logic             last,
   output logic             empty
);
   localparam int QW = NB * DW;

   generate
      if (NB < 2) begin : g_bad_nb
         $error("cbs_inj_queue: queue needs at least two byte lanes");
      end
   endgenerate

   logic [DW-1:0] lane_q [NB];

   for (genvar i = 0; i < NB; i++) begin : g_lane
      if (i == NB - 1) begin : g_top
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     lane_q[i] <= '0;
            else if (load)  lane_q[i] <= load_val[i*DW +: DW];
            else if (shift) lane_q[i] <= '0;
         end
      end else begin : g_mid
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     lane_q[i] <= '0;
            else if (load)  lane_q[i] <= load_val[i*DW +: DW];
            else if (shift) lane_q[i] <= lane_q[i+1];
         end
      end
   end

   logic [QW-1:0] flat;
   always_comb begin
      for (int i = 0; i < NB; i++) flat[i*DW +: DW] = lane_q[i];
   end

   assign head  = lane_q[0];
   assign last  = (flat[QW-1:DW] == '0);
   assign empty = (flat == '0);

   // R7
   queue_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |=> (flat == ($past(flat) >> DW)));
endmodule

// File: rtl/cart_bus_seq.sv
module cart_bus_seq
   import cbs_pkg::*;
#(
   parameter int AW       = 13,
   parameter int DW       = 8,
   parameter int CW       = 8,
   parameter int QBYTES   = 4,
   parameter int CART_BIT = 12,
   parameter int GUARD_LO = 8,
   parameter int GUARD_HI = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cyc_stb,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data_in,
   input  logic          rd_wr_n,
   input  logic          bank_sw,
   input  logic          ram_wr_sel,
   input  logic          copy_sel,
   input  logic [DW-1:0] rom_data,
   input  logic [CW-1:0] copy_len_cycles,
   output logic          drive_en,
   output logic [DW-1:0] data_out,
   output logic          contention_err,
   output logic          prev_offset,
   output logic          wr_go,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          copy_go
);
   localparam int QW = QBYTES * DW;

   generate
      if (DW != 8) begin : g_bad_dw
         $error("cart_bus_seq: opcodes need an 8-bit data bus");
      end
      if (QBYTES < 3) begin : g_bad_q
         $error("cart_bus_seq: queue must hold opcode and two address bytes");
      end
      if (AW > 2 * DW || CART_BIT >= AW) begin : g_bad_aw
         $error("cart_bus_seq: address width does not fit the jump operand");
      end
   endgenerate

   cbs_state_e    st_q;
   logic          drv_q, err_q, poff_q, wr_go_q, copy_go_q;
   logic [DW-1:0] dout_q;
   logic [AW-1:0] lat_a_q;
   logic [DW-1:0] lat_d_q;

   logic cart, rd, rep, far;
   logic bz_zero, q_last, q_empty;
   logic [DW-1:0] q_head;
   logic [QW-1:0] jmp_word;
   logic launch, bz_dec, q_shift, contend;

   assign cart = addr[CART_BIT];
   assign rd   = cart && rd_wr_n;

   cbs_addr_track #(.AW(AW), .GUARD_LO(GUARD_LO), .GUARD_HI(GUARD_HI)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (cyc_stb),
      .addr     (addr),
      .ref_addr (lat_a_q),
      .repeat_o (rep),
      .far_move (far)
   );

   assign launch  = cyc_stb && (st_q == ST_EBUSY) && !rep && far && cart;
   assign bz_dec  = cyc_stb && (st_q == ST_BUSY);
   assign q_shift = cyc_stb && (st_q == ST_INJ) && !rep && cart;
   assign contend = cyc_stb && !rd_wr_n && ((st_q == ST_BUSY) || launch);

   always_comb begin
      jmp_word = '0;
      jmp_word[DW-1:0]      = JMP_OP;
      jmp_word[3*DW-1:DW]   = (2*DW)'(addr);
   end

   cbs_busy_ctr #(.CW(CW)) u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (launch),
      .load_val (copy_len_cycles),
      .dec      (bz_dec),
      .zero     (bz_zero)
   );

   cbs_inj_queue #(.NB(QBYTES), .DW(DW)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (launch),
      .load_val (jmp_word),
      .shift    (q_shift),
      .head     (q_head),
      .last     (q_last),
      .empty    (q_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_NORM;
         drv_q     <= 1'b0;
         dout_q    <= '0;
         err_q     <= 1'b0;
         poff_q    <= 1'b0;
         wr_go_q   <= 1'b0;
         copy_go_q <= 1'b0;
         lat_a_q   <= '0;
         lat_d_q   <= '0;
      end else begin
         wr_go_q   <= 1'b0;
         copy_go_q <= 1'b0;
         if (cyc_stb) begin
            if (contend) err_q <= 1'b1;
            if (st_q == ST_BUSY) begin
               drv_q  <= 1'b1;
               dout_q <= NOP_OP;
               poff_q <= 1'b0;
               if (bz_zero) st_q <= q_empty ? ST_NORM : ST_INJ;
            end else if (!rep) begin
               poff_q <= 1'b0;
               unique case (st_q)
                  ST_NORM: begin
                     if (bank_sw) begin
                        drv_q <= rd;
                        if (rd) dout_q <= rom_data;
                        st_q <= ST_SFETCH;
                     end else if (cart && ram_wr_sel) begin
                        lat_a_q <= addr;
                        lat_d_q <= data_in;
                        drv_q   <= 1'b0;
                        st_q    <= ST_FHW;
                     end else if (cart && copy_sel && !rd_wr_n) begin
                        lat_a_q <= addr;
                        drv_q   <= 1'b0;
                        st_q    <= ST_EBUSY;
                     end else begin
                        drv_q <= rd;
                        if (rd) dout_q <= rom_data;
                     end
                  end
                  ST_SFETCH: begin
                     if (cart) begin
                        drv_q  <= rd;
                        if (rd) dout_q <= rom_data;
                        poff_q <= 1'b1;
                        st_q   <= ST_NORM;
                     end else begin
                        drv_q <= 1'b0;
                     end
                  end
                  ST_FHW: begin
                     if (!far) begin
                        lat_a_q <= addr;
                        lat_d_q <= data_in;
                        drv_q   <= 1'b0;
                     end else begin
                        drv_q   <= rd;
                        if (rd) dout_q <= rom_data;
                        poff_q  <= 1'b1;
                        wr_go_q <= 1'b1;
                        st_q    <= ST_NORM;
                     end
                  end
                  ST_EBUSY: begin
                     if (!far) begin
                        drv_q <= 1'b0;
                     end else if (cart) begin
                        drv_q     <= 1'b1;
                        dout_q    <= NOP_OP;
                        copy_go_q <= 1'b1;
                        st_q      <= ST_BUSY;
                     end else begin
                        drv_q <= 1'b0;
                        st_q  <= ST_NORM;
                     end
                  end
                  ST_INJ: begin
                     if (cart) begin
                        drv_q  <= 1'b1;
                        dout_q <= q_head;
                        if (q_last) st_q <= ST_NORM;
                     end else begin
                        drv_q <= 1'b0;
                     end
                  end
                  default: st_q <= ST_NORM;
               endcase
            end
         end
      end
   end

   assign drive_en       = drv_q;
   assign data_out       = dout_q;
   assign contention_err = err_q;
   assign prev_offset    = poff_q;
   assign wr_go          = wr_go_q;
   assign wr_addr        = lat_a_q;
   assign wr_data        = lat_d_q;
   assign copy_go        = copy_go_q;

   // R1
   repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_stb && rep && st_q != ST_BUSY) |=>
         ($stable(drive_en) && $stable(data_out) && !wr_go && !copy_go));
   // R3
   single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_go, copy_go}));
   // R4
   copy_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy_go |-> (drive_en && data_out == NOP_OP));
   // R6
   busy_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BUSY) |-> (drive_en && data_out == NOP_OP));
   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      contention_err |=> contention_err);
endmodule

// File: tb/sim_cart_bus_seq.sv
`timescale 1ns/1ps
module sim_cart_bus_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_stb = 1'b0;
   logic [12:0] addr = '0;
   logic [7:0]  data_in = '0;
   logic        rd_wr_n = 1'b1;
   logic        bank_sw = 1'b0, ram_wr_sel = 1'b0, copy_sel = 1'b0;
   logic [7:0]  rom_data = '0;
   logic [7:0]  copy_len_cycles = 8'd2;
   logic        drive_en, contention_err, prev_offset, wr_go, copy_go;
   logic [7:0]  data_out, wr_data;
   logic [12:0] wr_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cart_bus_seq u0 (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .addr(addr),
      .data_in(data_in), .rd_wr_n(rd_wr_n), .bank_sw(bank_sw),
      .ram_wr_sel(ram_wr_sel), .copy_sel(copy_sel), .rom_data(rom_data),
      .copy_len_cycles(copy_len_cycles), .drive_en(drive_en),
      .data_out(data_out), .contention_err(contention_err),
      .prev_offset(prev_offset), .wr_go(wr_go), .wr_addr(wr_addr),
      .wr_data(wr_data), .copy_go(copy_go)
   );

   typedef struct packed {
      logic [12:0] a;
      logic        rw;
      logic        bsw;
      logic        ramw;
      logic        cpy;
      logic [7:0]  din;
      logic [7:0]  rom;
      logic        drv;
      logic [7:0]  dout;
      logic        poff;
      logic        wgo;
      logic        cgo;
      logic [12:0] wa;
      logic [7:0]  wd;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{13'h1000,1'b1,1'b0,1'b0,1'b0,8'h00,8'h11, 1'b1,8'h11,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1000,1'b1,1'b0,1'b0,1'b0,8'h00,8'h22, 1'b1,8'h11,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1001,1'b1,1'b0,1'b0,1'b0,8'h00,8'h33, 1'b1,8'h33,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h0405,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00, 1'b0,8'h00,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h0080,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b0,8'h00,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1002,1'b1,1'b0,1'b0,1'b0,8'h00,8'h44, 1'b1,8'h44,1'b1,1'b0,1'b0,13'h0,8'h00},
      '{13'h1003,1'b1,1'b0,1'b0,1'b0,8'h00,8'h55, 1'b1,8'h55,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1100,1'b0,1'b0,1'b1,1'b0,8'h5A,8'h00, 1'b0,8'h00,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1200,1'b0,1'b0,1'b1,1'b0,8'h5B,8'h00, 1'b0,8'h00,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1004,1'b1,1'b0,1'b0,1'b0,8'h00,8'h66, 1'b1,8'h66,1'b1,1'b1,1'b0,13'h1200,8'h5B},
      '{13'h1005,1'b1,1'b0,1'b0,1'b0,8'h00,8'h77, 1'b1,8'h77,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1300,1'b0,1'b0,1'b0,1'b1,8'h07,8'h00, 1'b0,8'h00,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1A3C,1'b1,1'b0,1'b0,1'b0,8'h00,8'h99, 1'b1,8'hEA,1'b0,1'b0,1'b1,13'h0,8'h00},
      '{13'h1A3D,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b1,8'hEA,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1A3E,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b1,8'hEA,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1A3F,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b1,8'hEA,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1A40,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b1,8'h4C,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1A40,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b1,8'h4C,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1A41,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b1,8'h3C,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1A42,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b1,8'h1A,1'b0,1'b0,1'b0,13'h0,8'h00},
      '{13'h1A3C,1'b1,1'b0,1'b0,1'b0,8'h00,8'h12, 1'b1,8'h12,1'b0,1'b0,1'b0,13'h0,8'h00}
   };

   task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic [12:0] a, input logic rw, input logic bsw,
                      input logic ramw, input logic cpy, input logic [7:0] din,
                      input logic [7:0] rom);
      addr = a; rd_wr_n = rw; bank_sw = bsw; ram_wr_sel = ramw;
      copy_sel = cpy; data_in = din; rom_data = rom; cyc_stb = 1'b1;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      cyc_stb = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      do_reset();
      // R9: reset state
      expect_eq("R9 drive_en after reset", drive_en, 0);
      expect_eq("R9 contention_err after reset", contention_err, 0);
      expect_eq("R9 pulses after reset", {wr_go, copy_go}, 0);

      copy_len_cycles = 8'd2;
      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i].a, VEC[i].rw, VEC[i].bsw, VEC[i].ramw, VEC[i].cpy, VEC[i].din, VEC[i].rom);
         expect_eq($sformatf("vec%0d drive_en (R1 R2 R3 R6 R7 R10)", i), drive_en, VEC[i].drv);
         if (VEC[i].drv)
            expect_eq($sformatf("vec%0d data_out (R1 R4 R7 R10)", i), data_out, VEC[i].dout);
         expect_eq($sformatf("vec%0d prev_offset (R2 R3)", i), prev_offset, VEC[i].poff);
         expect_eq($sformatf("vec%0d wr_go (R3)", i), wr_go, VEC[i].wgo);
         expect_eq($sformatf("vec%0d copy_go (R4)", i), copy_go, VEC[i].cgo);
         if (VEC[i].wgo)
            expect_eq($sformatf("vec%0d wr_addr/wr_data (R3)", i), {11'd0, wr_addr, wr_data},
                      {11'd0, VEC[i].wa, VEC[i].wd});
         expect_eq($sformatf("vec%0d contention_err (R8)", i), contention_err, 0);
      end

      // R5: launch address with bit 12 clear abandons the copy
      cyc(13'h1310, 1'b0, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00);
      cyc(13'h1210, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 8'h00);
      expect_eq("R5 guard-bit move keeps waiting", {drive_en, copy_go}, 0);
      cyc(13'h0300, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      expect_eq("R5 no copy, bus floats", {drive_en, copy_go}, 0);
      cyc(13'h1020, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h5C);
      expect_eq("R5 back to plain access", {drive_en, data_out}, {1'b1, 8'h5C});

      // R4 R6 R7 R8: copy of length 3, write while busy, gap in injection
      copy_len_cycles = 8'd3;
      cyc(13'h1320, 1'b0, 1'b0, 1'b0, 1'b1, 8'h09, 8'h00);
      cyc(13'h1800, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      expect_eq("R4 launch drives NOP with copy_go", {drive_en, data_out, copy_go}, {1'b1, 8'hEA, 1'b1});
      cyc(13'h1801, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      expect_eq("R8 write while busy sets contention_err", contention_err, 1);
      cyc(13'h1802, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      cyc(13'h1803, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      cyc(13'h1804, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      expect_eq("R6 last busy strobe still drives NOP", {drive_en, data_out}, {1'b1, 8'hEA});
      cyc(13'h1805, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF);
      expect_eq("R7 first injected byte is jump opcode", {drive_en, data_out}, {1'b1, 8'h4C});
      cyc(13'h0090, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF);
      expect_eq("R7 non-cartridge access floats", drive_en, 0);
      cyc(13'h1806, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF);
      expect_eq("R7 zero low address byte emitted", {drive_en, data_out}, {1'b1, 8'h00});
      cyc(13'h1807, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF);
      expect_eq("R7 high address byte emitted", {drive_en, data_out}, {1'b1, 8'h18});
      cyc(13'h1808, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h71);
      expect_eq("R7 queue drained, plain read", {drive_en, data_out}, {1'b1, 8'h71});
      expect_eq("R8 contention_err stays set", contention_err, 1);

      // R9: reset clears the sticky flag
      do_reset();
      expect_eq("R9 reset clears contention_err", {contention_err, drive_en}, 0);

      // R8: write during injection is not contention (zero-length busy)
      copy_len_cycles = 8'd0;
      cyc(13'h1330, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 8'h00);
      cyc(13'h1500, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      expect_eq("R4 launch after reset", copy_go, 1);
      cyc(13'h1501, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      expect_eq("R6 zero length busy one strobe", {drive_en, data_out}, {1'b1, 8'hEA});
      cyc(13'h1502, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      expect_eq("R8 injected byte on write", {drive_en, data_out}, {1'b1, 8'h4C});
      expect_eq("R8 no contention in injection", contention_err, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule